// File: doc/BRIEF.md
# Clock-Style Not-Recently-Used Frame Victim Selector

This block picks which physical memory frame to give up when a new page has to be brought in. For each frame it keeps a reference flag and a dirty flag. The reference flag is raised by a notification that the frame was accessed. The dirty flag is raised by a separate notification that the frame was written. A circular hand points at one frame. It keeps its position from one replacement request to the next.

A replacement request starts a sweep. The sweep looks at one frame per clock. A frame whose reference flag is raised gets that flag lowered, and the hand moves on. The first frame found with its flag lowered becomes the victim. Its index is returned with a one-cycle done pulse, and the hand is left on the frame after it.

An optional clean-preferring mode is chosen per request. In this mode the first full pass also skips frames that are unreferenced but dirty. If that pass finds nothing, the sweep falls back to the first unreferenced frame, whether dirty or clean. A fill notification tells the block that new content has been loaded into a frame, and it clears both flags of that frame.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, `done` is 0 and `victim` is 0. Every reference and dirty flag is clear and the hand points at frame 0, so the first request returns frame 0.
- R2: `ref_vld` raises the reference flag of frame `ref_idx`. `wr_vld` raises only the dirty flag of frame `wr_idx`: a written frame that was never referenced can still be chosen by a plain sweep.
- R3: A request (`req`=1 while idle) is taken at a clock edge, and the frame under the hand is examined at each later edge. The edge that examines the victim drives `done`=1 for exactly one cycle, with the victim index on `victim`. If k frames are examined, `done` is seen k+1 cycles after the request edge's cycle. A `req` during a sweep is ignored and produces no second pulse.
- R4: A frame under the hand whose reference flag is raised is not chosen. Its flag is lowered and the hand moves to the next frame.
- R5: The hand moves at most one frame per clock. It wraps from frame NFRAMES-1 to frame 0.
- R6: After a victim is chosen, the hand rests on the frame after the victim. The next request starts its sweep there.
- R7: When a reference notification and a sweep clear hit the same frame in the same cycle, the frame's reference flag stays raised.
- R8: With `prefer_clean`=1, during the first NFRAMES examinations only a frame with both flags clear is chosen. A frame that is unreferenced but dirty is passed over, and its flags are not changed.
- R9: In clean-preferring mode, from the (NFRAMES+1)-th examination on, the first unreferenced frame is chosen even if it is dirty.
- R10: `fill_vld` clears both flags of frame `fill_idx`. A reference or write notification to the same frame in the same cycle wins for its own flag.
- R11: `prefer_clean` is sampled only on the request edge. Changing it during a sweep has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_vld | input | 1 | Frame-accessed notification |
| ref_idx | input | IDXW | Frame that was accessed |
| wr_vld | input | 1 | Frame-written notification |
| wr_idx | input | IDXW | Frame that was written |
| fill_vld | input | 1 | Frame-refilled notification |
| fill_idx | input | IDXW | Frame that was refilled |
| req | input | 1 | Replacement request |
| prefer_clean | input | 1 | Clean-preferring mode for this request |
| done | output | 1 | One-cycle pulse: the victim is valid |
| victim | output | IDXW | Index of the chosen frame, held until the next choice |

## Verification
The flags and the hand are hidden. A wrong value in any of them shows up only as a wrong victim index, or as a `done` pulse that comes early or late, on the next request that reaches the affected frame. The bench therefore compares `done` and `victim` with its own model on every clock. It also counts the sweep latency of each request, because a flag that was not lowered, or a hand that did not wrap, changes that count before it changes any index. The same-cycle priority cases and the mode sampling are staged one clock apart, so that they move the victim or the latency by a known amount.

// File: rtl/nru_pkg.sv
package nru_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_SCAN
  } sweep_state_e;

  // Circular successor of a frame index in a table of n frames.
  function automatic int wrap_next(input int h, input int n);
    return (h + 1 >= n) ? 0 : h + 1;
  endfunction

endpackage

// File: rtl/nru_flag_array.sv
module nru_flag_array #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_vld,
  input  logic [IDXW-1:0]    ref_idx,
  input  logic               wr_vld,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic               fill_vld,
  input  logic [IDXW-1:0]    fill_idx,
  input  logic               clr_en,
  input  logic [IDXW-1:0]    clr_idx,
  output logic [NFRAMES-1:0] ref_bits,
  output logic [NFRAMES-1:0] dirty_bits
);

  for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
    logic ref_hit, wr_hit, fill_hit, clr_hit;
    assign ref_hit  = ref_vld  && (ref_idx  == IDXW'(i));
    assign wr_hit   = wr_vld   && (wr_idx   == IDXW'(i));
    assign fill_hit = fill_vld && (fill_idx == IDXW'(i));
    assign clr_hit  = clr_en   && (clr_idx  == IDXW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_bits[i]   <= 1'b0;
        dirty_bits[i] <= 1'b0;
      end else begin
        if (ref_hit)                  ref_bits[i] <= 1'b1;
        else if (clr_hit || fill_hit) ref_bits[i] <= 1'b0;
        if (wr_hit)                   dirty_bits[i] <= 1'b1;
        else if (fill_hit)            dirty_bits[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nru_hand.sv
module nru_hand
  import nru_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3,
  parameter int STEPW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            adv,
  output logic [IDXW-1:0] hand,
  output logic            pass_done
);

  logic [STEPW-1:0] step;

  assign pass_done = (step == STEPW'(NFRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hand <= '0;
      step <= '0;
    end else begin
      if (adv) hand <= IDXW'(wrap_next(int'(hand), NFRAMES));
      if (start)                  step <= '0;
      else if (adv && !pass_done) step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/nru_sweep_ctrl.sv
module nru_sweep_ctrl
  import nru_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            prefer_clean,
  input  logic            cur_ref,
  input  logic            cur_dirty,
  input  logic            pass_done,
  input  logic [IDXW-1:0] hand,
  output logic            start,
  output logic            adv,
  output logic            clr_en,
  output logic            pick,
  output logic            mode_clean,
  output logic            done,
  output logic [IDXW-1:0] victim
);

  sweep_state_e state;
  logic scanning, fallback;

  assign scanning = (state == ST_SCAN);
  assign start    = (state == ST_IDLE) && req;
  assign fallback = !mode_clean || pass_done;
  assign pick     = scanning && !cur_ref && (fallback || !cur_dirty);
  assign adv      = scanning;
  assign clr_en   = scanning && cur_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_clean <= 1'b0;
      done       <= 1'b0;
      victim     <= '0;
    end else begin
      done <= pick;
      if (pick) victim <= hand;
      if (start) begin
        state      <= ST_SCAN;
        mode_clean <= prefer_clean;
      end else if (pick) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int NFRAMES = 8,
  parameter int IDXW    = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_vld,
  input  logic [IDXW-1:0] ref_idx,
  input  logic            wr_vld,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            fill_vld,
  input  logic [IDXW-1:0] fill_idx,
  input  logic            req,
  input  logic            prefer_clean,
  output logic            done,
  output logic [IDXW-1:0] victim
);

  localparam int STEPW = $clog2(NFRAMES + 1) + 1;

  logic [NFRAMES-1:0] ref_bits, dirty_bits;
  logic [IDXW-1:0]    hand;
  logic               start, adv, clr_en, pick, mode_clean, pass_done;
  logic               cur_ref, cur_dirty;

  assign cur_ref   = ref_bits[hand];
  assign cur_dirty = dirty_bits[hand];

  nru_flag_array #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ref_vld(ref_vld), .ref_idx(ref_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx),
    .fill_vld(fill_vld), .fill_idx(fill_idx),
    .clr_en(clr_en), .clr_idx(hand),
    .ref_bits(ref_bits), .dirty_bits(dirty_bits)
  );

  nru_hand #(.NFRAMES(NFRAMES), .IDXW(IDXW), .STEPW(STEPW)) u_hand (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .hand(hand), .pass_done(pass_done)
  );

  nru_sweep_ctrl #(.IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .prefer_clean(prefer_clean),
    .cur_ref(cur_ref), .cur_dirty(cur_dirty), .pass_done(pass_done),
    .hand(hand), .start(start), .adv(adv), .clr_en(clr_en), .pick(pick),
    .mode_clean(mode_clean), .done(done), .victim(victim)
  );

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk
  import nru_pkg::*;
#(
  parameter int NFRAMES = 8,
  parameter int IDXW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_vld,
  input logic [IDXW-1:0]    ref_idx,
  input logic               wr_vld,
  input logic [IDXW-1:0]    wr_idx,
  input logic               fill_vld,
  input logic [IDXW-1:0]    fill_idx,
  input logic               clr_en,
  input logic [IDXW-1:0]    hand,
  input logic [NFRAMES-1:0] ref_bits,
  input logic [NFRAMES-1:0] dirty_bits,
  input logic               done,
  input logic [IDXW-1:0]    victim
);

  logic [NFRAMES-1:0] prev_ref;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ref <= '0;
    else        prev_ref <= ref_bits;
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_victim_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(victim) < NFRAMES));

  assert_victim_unref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !prev_ref[victim]);

  assert_hand_after_victim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hand == IDXW'(wrap_next(int'(victim), NFRAMES))));

  assert_hand_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hand) |-> (hand == IDXW'(wrap_next(int'($past(hand)), NFRAMES))));

  assert_ref_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |=> ref_bits[$past(ref_idx)]);

  assert_sweep_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(ref_vld && ref_idx == hand)) |=> !ref_bits[$past(hand)]);

  assert_fill_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && !(wr_vld && wr_idx == fill_idx)) |=> !dirty_bits[$past(fill_idx)]);

endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_vld(ref_vld), .ref_idx(ref_idx),
  .wr_vld(wr_vld), .wr_idx(wr_idx), .fill_vld(fill_vld), .fill_idx(fill_idx),
  .clr_en(clr_en), .hand(hand), .ref_bits(ref_bits), .dirty_bits(dirty_bits),
  .done(done), .victim(victim)
);

// File: tb/tb_nru_victim_sel.sv
`timescale 1ns/1ps
module tb_nru_victim_sel;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_vld = 0, wr_vld = 0, fill_vld = 0, req = 0, prefer_clean = 0;
  logic [W-1:0] ref_idx = 0, wr_idx = 0, fill_idx = 0;
  logic done;
  logic [W-1:0] victim;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  nru_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_vld(ref_vld), .ref_idx(ref_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .fill_vld(fill_vld), .fill_idx(fill_idx),
    .req(req), .prefer_clean(prefer_clean), .done(done), .victim(victim)
  );

  // Behavioural model: flags as integer arrays, hand as integer.
  int mref[N], mdirty[N];
  int mhand = 0, msteps = 0, mvict = 0;
  bit msweeping = 0, mclean = 0, mdone = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mref[i]) begin mref[i] = 0; mdirty[i] = 0; end
      mhand = 0; msteps = 0; mvict = 0; msweeping = 0; mclean = 0; mdone = 0;
    end else begin
      int clear_at = -1;
      mdone = 0;
      if (msweeping) begin
        bool_pick(clear_at);
      end else if (req) begin
        msweeping = 1; mclean = prefer_clean; msteps = 0;
      end
      if (fill_vld) begin mref[fill_idx] = 0; mdirty[fill_idx] = 0; end
      if (clear_at >= 0) mref[clear_at] = 0;
      if (ref_vld) mref[ref_idx] = 1;
      if (wr_vld) mdirty[wr_idx] = 1;
    end
  end

  task automatic bool_pick(output int clear_at);
    bit relaxed = !mclean || (msteps >= N);
    clear_at = -1;
    if (mref[mhand] == 0 && (relaxed || mdirty[mhand] == 0)) begin
      mdone = 1; mvict = mhand; msweeping = 0;
    end else if (mref[mhand] != 0) begin
      clear_at = mhand;
    end
    mhand = (mhand + 1) % N;
    msteps++;
  endtask

  task automatic check(input string req_tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "done vs model", int'(done), int'(mdone));
      check(tag, "victim vs model", int'(victim), mvict);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic touch(input int f);
    @(negedge clk); ref_vld = 1; ref_idx = W'(f);
    @(negedge clk); ref_vld = 0;
  endtask

  task automatic write(input int f);
    @(negedge clk); wr_vld = 1; wr_idx = W'(f);
    @(negedge clk); wr_vld = 0;
  endtask

  // Issue a request; return the victim and the latency in cycles.
  task automatic request(input bit clean, input bit drop_mode, output int v, output int lat);
    @(negedge clk); req = 1; prefer_clean = clean; lat = 0;
    forever begin
      @(negedge clk); lat++;
      req = 0;
      if (drop_mode) prefer_clean = 0;
      if (done) break;
      if (lat > 100) break;
    end
    v = int'(victim);
    prefer_clean = 0;
  endtask

  initial begin
    int v, lat;
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", "done at reset", int'(done), 0);
    check("R1", "victim at reset", int'(victim), 0);
    rst_n = 1;
    @(negedge clk);
    request(0, 0, v, lat);
    check("R1", "first victim", v, 0);
    check("R3", "latency immediate hit", lat, 2);

    tag = "R4";
    touch(1); touch(2); touch(3);
    request(0, 0, v, lat);
    check("R4", "skip referenced", v, 4);
    check("R3", "latency four examined", lat, 5);
    tag = "R6";
    request(0, 0, v, lat);
    check("R6", "hand after victim", v, 5);

    tag = "R5";
    touch(6); touch(7);
    request(0, 0, v, lat);
    check("R5", "wrap to frame 0", v, 0);

    tag = "R7";
    for (int f = 0; f < N; f++) touch(f);
    @(negedge clk); req = 1;
    @(negedge clk); req = 0; ref_vld = 1; ref_idx = 3'd1;
    @(negedge clk); ref_vld = 0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R7", "reference beats clear", int'(victim), 2);

    tag = "R10";
    touch(3);
    @(negedge clk); fill_vld = 1; fill_idx = 3'd3;
    @(negedge clk); fill_vld = 0;
    request(0, 0, v, lat);
    check("R10", "fill clears reference", v, 3);
    @(negedge clk); fill_vld = 1; fill_idx = 3'd4; ref_vld = 1; ref_idx = 3'd4;
    @(negedge clk); fill_vld = 0; ref_vld = 0;
    request(0, 0, v, lat);
    check("R10", "reference beats fill", v, 5);

    tag = "R8";
    write(6); write(7);
    request(1, 0, v, lat);
    check("R8", "skip dirty frames", v, 0);
    check("R8", "latency clean pick", lat, 4);
    request(0, 0, v, lat);
    check("R2", "next victim", v, 1);

    tag = "R9";
    for (int f = 0; f < N; f++) write(f);
    touch(2); touch(3);
    request(1, 0, v, lat);
    check("R9", "fallback victim", v, 2);
    check("R9", "fallback latency", lat, 10);

    tag = "R11";
    request(1, 1, v, lat);
    check("R11", "mode latched victim", v, 3);
    check("R11", "mode latched latency", lat, 10);

    tag = "R2";
    @(negedge clk); fill_vld = 1; fill_idx = 3'd4;
    @(negedge clk); fill_vld = 0;
    request(1, 0, v, lat);
    check("R10", "fill clears dirty", v, 4);
    request(0, 0, v, lat);
    check("R2", "write leaves reference clear", v, 5);
    check("R2", "write leaves reference latency", lat, 2);

    tag = "R3";
    touch(6); touch(7);
    @(negedge clk); req = 1;
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R3", "victim with extra req", int'(victim), 0);
    lat = 0;
    repeat (6) begin @(negedge clk); if (done) lat++; end
    check("R3", "extra req ignored", lat, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule